// File: doc/BRIEF.md
# Transport Stream Word Unpacker

The block receives a stream of 32-bit words in which up to four transport-stream channels are interleaved. Each word carries a channel code, a 3-bit running sequence count, a packet-start flag, an upstream overflow flag and three payload bytes. The block rebuilds each channel's 188-byte packets from these words. Each packet is 63 words long: the first 62 words give three bytes each and the final word gives two.

Each channel keeps its own word position inside the current packet, a flag that records whether a start-marked word has been seen, and the last sequence count with a valid bit. The output is a byte stream with a valid/ready handshake. Each byte is tagged with its channel number and with packet-start and packet-end markers. Overflow and sequence-loss conditions appear as single-cycle pulses, one bit per channel.

Top module: `ts_word_unpacker`

## Requirements
- R1: The channel code in bits 31:29 selects the channel: code 1 gives channel 0, code 2 gives channel 1, code 3 gives channel 2 and code 4 gives channel 3, and that number appears on `out_chan`. A word with code 0, 5, 6 or 7 produces no output byte and no event.
- R2: After reset, every word of a channel is dropped until a word of that channel arrives with bit 25 set. A dropped word produces no output byte and no event.
- R3: A word with bit 25 set restarts its channel's packet at word position 0, including in the middle of a packet. Its first byte is emitted with `out_sop` high.
- R4: Each accepted word emits its bytes in the order bits 23:16, then bits 15:8, then bits 7:0.
- R5: At word position 62, the 63rd word of a packet, only bits 23:16 and 15:8 are emitted, and the second of these carries `out_eop`. This makes 62*3+2 = 188 bytes per packet. The position then wraps to 0, so the next accepted word starts a new packet with `out_sop`. `out_sop` and `out_eop` are never high on the same byte.
- R6: An accepted word with bit 24 set pulses `ovf_evt[channel]` high for exactly one cycle, in the cycle after the word is accepted.
- R7: The sequence count is in bits 28:26. If an accepted word's count is not the count of the previous accepted word of that channel plus one (mod 8), `loss_evt[channel]` pulses for one cycle, in the cycle after the word is accepted. The check is skipped for the first accepted word after reset. Every accepted word, including a mismatching one, becomes the new reference count.
- R8: Channels are independent. Interleaved words of different channels each continue their own packet position and sequence reference.
- R9: While `out_valid` is high and `out_ready` is low, the output byte and its tags hold steady. `in_ready` stays low until all bytes of the current word have been taken.
- R10: A synchronous reset (`rst` high at a clock edge) returns every channel to not-started with an unknown sequence reference, and empties the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 32 | Packed input word |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the byte |
| out_byte | output | 8 | Payload byte |
| out_chan | output | 2 | Channel of the byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | 188th byte of a packet |
| ovf_evt | output | 4 | Per-channel overflow pulse |
| loss_evt | output | 4 | Per-channel sequence-loss pulse |

## Verification
The assertions check on every cycle the properties that hold at all times: the output holds under backpressure, start and end markers never fall on the same byte, a channel's word position stays inside a packet, at most one channel takes each word, a word with a bad channel code leaves the outputs idle, and a loss pulse appears only once a reference count exists. Only the bench scenarios can show the values themselves. These are the channel mapping for each code, the byte order, the exact 188-byte framing with the dropped low byte, the wrap into the next packet, restarts in the middle of a packet, which channel a pulse lands on, and the state left after a reset in mid-stream.

// File: rtl/ts_unpack_pkg.sv
package ts_unpack_pkg;
    parameter int CHANNELS        = 4;
    parameter int WORDS_PER_PKT   = 63;
    parameter int BYTES_PER_WORD  = 3;
    parameter int LAST_WORD_BYTES = 2;

    localparam int CH_W     = $clog2(CHANNELS);
    localparam int POS_W    = $clog2(WORDS_PER_PKT);
    localparam int SEQ_W    = 3;
    localparam int CODE_W   = 3;
    localparam int PAY_W    = 8 * BYTES_PER_WORD;
    localparam int NB_W     = $clog2(BYTES_PER_WORD + 1);

    // field positions of the packed word
    localparam int CODE_LSB  = 29;
    localparam int SEQ_LSB   = 26;
    localparam int START_BIT = 25;
    localparam int OVF_BIT   = 24;

    typedef struct packed {
        logic              chan_ok;
        logic [CH_W-1:0]   chan;
        logic [SEQ_W-1:0]  seq;
        logic              start;
        logic              ovf;
        logic [PAY_W-1:0]  payload;
    } word_fields_t;
endpackage

// File: rtl/ts_word_decode.sv
module ts_word_decode
    import ts_unpack_pkg::*;
(
    input  logic [31:0]  word,
    output word_fields_t fields
);
    logic [CODE_W-1:0] code;

    always_comb begin
        code           = word[CODE_LSB +: CODE_W];
        fields.chan_ok = (code != '0) && (32'(code) <= CHANNELS);
        fields.chan    = CH_W'(code - CODE_W'(1));
        fields.seq     = word[SEQ_LSB +: SEQ_W];
        fields.start   = word[START_BIT];
        fields.ovf     = word[OVF_BIT];
        fields.payload = word[PAY_W-1:0];
    end
endmodule

// File: rtl/ts_chan_track.sv
module ts_chan_track
    import ts_unpack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             start,
    input  logic             ovf,
    input  logic [SEQ_W-1:0] seq,
    output logic             take,
    output logic [POS_W-1:0] pos_now,
    output logic             ovf_evt,
    output logic             loss_evt
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS_PER_PKT - 1);

    typedef struct packed {
        logic             started;
        logic [POS_W-1:0] pos;
        logic             known;
        logic [SEQ_W-1:0] seq;
        logic             ovf_evt;
        logic             loss_evt;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        take    = hit && (start || st_q.started);
        pos_now = start ? '0 : st_q.pos;
        st_d.ovf_evt  = take && ovf;
        st_d.loss_evt = take && st_q.known && (seq != SEQ_W'(st_q.seq + SEQ_W'(1)));
        if (take) begin
            st_d.started = 1'b1;
            st_d.known   = 1'b1;
            st_d.seq     = seq;
            st_d.pos     = (pos_now == LAST_POS) ? '0 : POS_W'(pos_now + POS_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ovf_evt  = st_q.ovf_evt;
    assign loss_evt = st_q.loss_evt;

    // R5
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.pos <= LAST_POS);

    // R7
    loss_known_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.loss_evt |-> $past(st_q.known));
endmodule

// File: rtl/ts_byte_serializer.sv
module ts_byte_serializer
    import ts_unpack_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PAY_W-1:0] data,
    input  logic [NB_W-1:0]  nbytes,
    input  logic [CH_W-1:0]  chan,
    input  logic             sop,
    input  logic             eop,
    output logic             busy,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_byte,
    output logic [CH_W-1:0]  out_chan,
    output logic             out_sop,
    output logic             out_eop
);
    typedef struct packed {
        logic [PAY_W-1:0] data;
        logic [NB_W-1:0]  rem;
        logic [CH_W-1:0]  chan;
        logic             first;
        logic             sop;
        logic             eop;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load && s_q.rem == '0) begin
            s_d.data  = data;
            s_d.rem   = nbytes;
            s_d.chan  = chan;
            s_d.first = 1'b1;
            s_d.sop   = sop;
            s_d.eop   = eop;
        end else if (s_q.rem != '0 && out_ready) begin
            s_d.data  = s_q.data << 8;
            s_d.rem   = NB_W'(s_q.rem - NB_W'(1));
            s_d.first = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy      = (s_q.rem != '0);
    assign out_valid = busy;
    assign out_byte  = s_q.data[PAY_W-1 -: 8];
    assign out_chan  = s_q.chan;
    assign out_sop   = s_q.first && s_q.sop;
    assign out_eop   = (s_q.rem == NB_W'(1)) && s_q.eop;

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_byte) && $stable(out_chan)
             && $stable(out_sop) && $stable(out_eop)));

    // R5
    sop_eop_excl_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sop && out_eop));
endmodule

// File: rtl/ts_word_unpacker.sv
module ts_word_unpacker
    import ts_unpack_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         in_word,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [7:0]          out_byte,
    output logic [CH_W-1:0]     out_chan,
    output logic                out_sop,
    output logic                out_eop,
    output logic [CHANNELS-1:0] ovf_evt,
    output logic [CHANNELS-1:0] loss_evt
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORDS_PER_PKT - 1);

    word_fields_t          f;
    logic                  accept;
    logic                  busy;
    logic [CHANNELS-1:0]   hit_vec;
    logic [CHANNELS-1:0]   take_vec;
    logic [POS_W-1:0]      pos_vec [CHANNELS];
    logic                  take;
    logic [POS_W-1:0]      pos_sel;
    logic [NB_W-1:0]       nbytes;

    ts_word_decode i_decode (
        .word   (in_word),
        .fields (f)
    );

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        assign hit_vec[c] = accept && f.chan_ok && (f.chan == CH_W'(c));

        ts_chan_track i_track (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit_vec[c]),
            .start    (f.start),
            .ovf      (f.ovf),
            .seq      (f.seq),
            .take     (take_vec[c]),
            .pos_now  (pos_vec[c]),
            .ovf_evt  (ovf_evt[c]),
            .loss_evt (loss_evt[c])
        );
    end

    always_comb begin
        take    = |take_vec;
        pos_sel = pos_vec[f.chan];
        nbytes  = (pos_sel == LAST_POS) ? NB_W'(LAST_WORD_BYTES) : NB_W'(BYTES_PER_WORD);
    end

    ts_byte_serializer i_ser (
        .clk       (clk),
        .rst       (rst),
        .load      (take),
        .data      (f.payload),
        .nbytes    (nbytes),
        .chan      (f.chan),
        .sop       (pos_sel == '0),
        .eop       (pos_sel == LAST_POS),
        .busy      (busy),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .out_chan  (out_chan),
        .out_sop   (out_sop),
        .out_eop   (out_eop)
    );

    // R8
    take_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take_vec));

    // R1
    bad_code_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !f.chan_ok) |=> (!out_valid && ovf_evt == '0 && loss_evt == '0));
endmodule

// File: tb/test_ts_word_unpacker.sv
module test_ts_word_unpacker;
    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_byte;
    logic [1:0]  out_chan;
    logic        out_sop, out_eop;
    logic [3:0]  ovf_evt, loss_evt;
    logic        rdy = 1;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [7:0] cb[$];
    logic [1:0] cc[$];
    bit         cs[$];
    bit         ce[$];
    int         ovf_cnt [4];
    int         loss_cnt [4];

    // entry: {channel valid, channel number}, indexed by code
    localparam logic [2:0] CODE_TAB [0:7] = '{3'b000, 3'b100, 3'b101, 3'b110,
                                              3'b111, 3'b000, 3'b000, 3'b000};

    assign out_ready = rdy;

    ts_word_unpacker i_ts_word_unpacker (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_byte(out_byte), .out_chan(out_chan), .out_sop(out_sop),
        .out_eop(out_eop), .ovf_evt(ovf_evt), .loss_evt(loss_evt)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) begin
                cb.push_back(out_byte); cc.push_back(out_chan);
                cs.push_back(out_sop);  ce.push_back(out_eop);
            end
            for (int c = 0; c < 4; c++) begin
                if (ovf_evt[c])  ovf_cnt[c]++;
                if (loss_evt[c]) loss_cnt[c]++;
            end
        end
    end

    function automatic logic [31:0] mk(int code, int seq, bit st, bit ov,
                                       logic [7:0] a, logic [7:0] b, logic [7:0] d);
        return {3'(code), 3'(seq), st, ov, a, b, d};
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_caps();
        cb.delete(); cc.delete(); cs.delete(); ce.delete();
        for (int c = 0; c < 4; c++) begin ovf_cnt[c] = 0; loss_cnt[c] = 0; end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        clear_caps();
    endtask

    task automatic send(logic [31:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1; in_word = w;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic flush();
        @(negedge clk);
        while (out_valid) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] exp_b[$];
        logic [7:0] held;
        int n;

        do_reset();
        // R10 reset state
        @(negedge clk);
        check(!out_valid && in_ready && ovf_evt == 0 && loss_evt == 0,
              "R10 reset idle", {out_valid, in_ready}, 1);

        // R1 table of channel codes
        for (int i = 0; i < 8; i++) begin
            clear_caps();
            send(mk(i, 0, 1, 1, 8'h10 + 8'(i), 8'h20, 8'h30));
            flush();
            n = CODE_TAB[i][2] ? 3 : 0;
            check(cb.size() == n, "R1 byte count", cb.size(), n);
            if (CODE_TAB[i][2] && cb.size() == 3) begin
                check(cc[0] == CODE_TAB[i][1:0] && cc[2] == CODE_TAB[i][1:0],
                      "R1 channel tag", cc[0], CODE_TAB[i][1:0]);
                check(ovf_cnt[CODE_TAB[i][1:0]] == 1, "R1 event on mapped channel",
                      ovf_cnt[CODE_TAB[i][1:0]], 1);
            end else begin
                check(ovf_cnt[0] + ovf_cnt[1] + ovf_cnt[2] + ovf_cnt[3] == 0,
                      "R1 no event for bad code", ovf_cnt[0], 0);
            end
        end

        // R2 words before start are dropped
        do_reset();
        send(mk(1, 0, 0, 1, 8'hA1, 8'hA2, 8'hA3));
        flush();
        check(cb.size() == 0 && ovf_cnt[0] == 0, "R2 drop before start", cb.size(), 0);
        send(mk(1, 1, 1, 0, 8'hB1, 8'hB2, 8'hB3));
        flush();
        check(cb.size() == 3 && cs[0], "R2 start accepted", cb.size(), 3);

        // R4 R5 full packet on channel 1
        do_reset();
        exp_b.delete();
        for (int k = 0; k < 63; k++) begin
            send(mk(2, k % 8, k == 0, 0, 8'(k), 8'(k + 100), 8'(k + 200)));
            exp_b.push_back(8'(k)); exp_b.push_back(8'(k + 100));
            if (k < 62) exp_b.push_back(8'(k + 200));
        end
        flush();
        check(cb.size() == 188, "R5 packet length", cb.size(), 188);
        n = 0;
        for (int j = 0; j < cb.size() && j < 188; j++)
            if (cb[j] != exp_b[j] || cc[j] != 2'd1 || cs[j] != (j == 0) || ce[j] != (j == 187)) n++;
        check(n == 0, "R4 byte order and markers", n, 0);
        check(loss_cnt[1] == 0, "R7 no loss on in-order counts", loss_cnt[1], 0);
        clear_caps();
        send(mk(2, 63 % 8, 0, 0, 8'h11, 8'h22, 8'h33));
        flush();
        check(cb.size() == 3 && cs[0] && !ce[2], "R5 wrap to new packet", cb.size(), 3);

        // R7 sequence loss then resync
        clear_caps();
        send(mk(2, 3, 0, 0, 8'h01, 8'h02, 8'h03));
        flush();
        check(loss_cnt[1] == 1, "R7 loss detected", loss_cnt[1], 1);
        send(mk(2, 4, 0, 0, 8'h01, 8'h02, 8'h03));
        flush();
        check(loss_cnt[1] == 1 && loss_cnt[0] + loss_cnt[2] + loss_cnt[3] == 0,
              "R7 reference updated", loss_cnt[1], 1);

        // R6 overflow pulse on channel 2
        clear_caps();
        send(mk(3, 0, 1, 1, 8'h01, 8'h02, 8'h03));
        flush();
        check(ovf_cnt[2] == 1 && ovf_cnt[0] + ovf_cnt[1] + ovf_cnt[3] == 0,
              "R6 overflow pulse", ovf_cnt[2], 1);

        // R3 restart mid-packet on channel 3
        do_reset();
        for (int k = 0; k < 5; k++) send(mk(4, k, k == 0, 0, 8'(k), 8'h00, 8'h00));
        send(mk(4, 5, 1, 0, 8'hEE, 8'h00, 8'h00));
        flush();
        n = 0;
        for (int j = 0; j < cs.size(); j++) if (cs[j]) n++;
        check(cb.size() == 18 && cs[0] && cs[15] && n == 2 && cb[15] == 8'hEE,
              "R3 mid-packet restart", n, 2);

        // R8 interleaving
        do_reset();
        send(mk(1, 0, 1, 0, 8'h01, 8'h02, 8'h03));
        send(mk(4, 6, 1, 0, 8'h41, 8'h42, 8'h43));
        send(mk(1, 1, 0, 0, 8'h04, 8'h05, 8'h06));
        send(mk(4, 7, 0, 0, 8'h44, 8'h45, 8'h46));
        flush();
        check(cb.size() == 12 && cc[0] == 0 && cc[3] == 3 && cc[6] == 0 && cc[9] == 3
              && cb[6] == 8'h04 && cb[11] == 8'h46 && !cs[6] && !cs[9],
              "R8 interleaved channels", cb.size(), 12);
        check(loss_cnt[0] + loss_cnt[3] == 0, "R8 independent sequence", loss_cnt[0], 0);

        // R9 backpressure
        clear_caps();
        rdy = 0;
        send(mk(1, 2, 0, 0, 8'hC1, 8'hC2, 8'hC3));
        held = out_byte;
        repeat (4) @(negedge clk);
        check(out_valid && !in_ready && out_byte == held && held == 8'hC1,
              "R9 hold under backpressure", out_byte, 8'hC1);
        rdy = 1;
        flush();
        check(cb.size() == 3 && cb[2] == 8'hC3, "R9 release", cb.size(), 3);

        // R10 reset in mid-stream
        do_reset();
        send(mk(1, 3, 0, 0, 8'h01, 8'h02, 8'h03));
        flush();
        check(cb.size() == 0, "R10 channel not started after reset", cb.size(), 0);
        send(mk(1, 6, 1, 0, 8'h01, 8'h02, 8'h03));
        flush();
        check(cb.size() == 3 && loss_cnt[0] == 0, "R10 sequence unknown after reset",
              loss_cnt[0], 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule